// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This block is a watchdog timer for a processor subsystem. It leaves reset already counting, with a long timeout and the whole-system reset as its fault action, so software must either service it or turn it off. A free-running divider turns pulses from a slow clock into counter steps, and a down-counter moves one step at a time toward zero. If the counter passes zero, or software restarts it too early, the block raises a fault. A one-time configuration decides what that fault does.

Software reaches the block through three word-wide registers on a plain read/write strobe interface. The configuration word can be written exactly once after power reset. That write sets the reload value, the window limit, the fault action and the idle/debug pause behaviour, and it can turn the timer off for good. A restart is a write to the command register that carries a fixed key. It is accepted only while the counter is at or below the window limit. Fault causes are held in a status word, and reading that word clears them. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `guard_timer`

## Requirements
- R1: After reset the status word (address 2) reads 0, the configuration word (address 1) reads 0x02FF_FFFF, all three fault outputs are low, and the counter runs with reload value 4095 and whole-system reset as its action.
- R2: The counter takes one step for every PRESCALE pulses on `slow_tick` (default 128). It faults on the (reload+1)-th step after it is loaded, then reloads and keeps counting.
- R3: The configuration word (address 1) takes effect on its first write after reset and also loads the counter. Every later write is ignored, and the readback keeps the first value. Layout: bits 11:0 reload, 23:12 window limit, 24 interrupt enable, 25 reset enable, 26 processor-only, 27 off, 28 pause-on-idle, 29 pause-on-debug.
- R4: If the single configuration write sets the off bit, the counter stops and restarts are ignored. No fault, status flag or output ever appears until the next power reset.
- R5: A restart is a write to address 0 with 0xA5 in bits 31:24 and bit 0 set. If the counter is at or below the window limit, the counter reloads. A write with any other key is ignored.
- R6: A keyed restart while the counter is above the window limit is an error. It sets status bit 1, leaves the counter unreloaded and triggers the fault action. A window limit equal to the reload value allows restarts at any time.
- R7: On a fault with reset enable set and processor-only clear, `sys_rst_req` pulses high for one cycle. With both set, `cpu_rst_req` pulses instead. With interrupt enable set, `fault_irq` stays high while any status flag is set.
- R8: Status bit 0 (underflow) and bit 1 (restart error) are sticky. A read of address 2 returns them and clears them in the same cycle.
- R9: Steps are suppressed while `cpu_idle` is high and pause-on-idle is set, and while `cpu_dbg_halt` is high and pause-on-debug is set. The same input without its pause bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| cpu_idle | input | 1 | Processor is in idle/sleep |
| cpu_dbg_halt | input | 1 | Processor is halted by a debugger |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 command, 1 configuration, 2 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sys_rst_req | output | 1 | One-cycle whole-system reset request |
| cpu_rst_req | output | 1 | One-cycle processor-only reset request |
| fault_irq | output | 1 | Fault interrupt level |

## Verification
A counter step lands on the same clock edge as the PRESCALE-th slow pulse. A fault pulse on `sys_rst_req` or `cpu_rst_req` is registered on that edge and lasts exactly one cycle. Status flags and `fault_irq` change on that edge too. A read clears the flags on the edge that ends the read cycle, and `reg_rdata` is valid during the read cycle itself. The bench sends slow pulses only in groups of PRESCALE, so each group is exactly one step. It samples at the falling edge right after the last pulse of a group, where a fault pulse is still visible. Read data is sampled inside the strobe cycle, and the effect of the clear is checked at the next falling edge.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int FLAG_LSB = 24;

  typedef enum logic [1:0] {
    ADDR_CMD  = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_STAT = 2'd2
  } reg_addr_e;

  typedef struct packed {
    logic dbg_hold;
    logic idle_hold;
    logic off;
    logic proc_only;
    logic rst_en;
    logic irq_en;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{dbg_hold: 1'b0, idle_hold: 1'b0, off: 1'b0,
                                     proc_only: 1'b0, rst_en: 1'b1, irq_en: 1'b0};
endpackage

// File: rtl/guard_tick_div.sv
module guard_tick_div #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  output logic step
);
  generate
    if (PRESCALE <= 1) begin : g_pass
      assign step = slow_tick;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (slow_tick)      pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
      end
      assign step = slow_tick && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/guard_cfg_lock.sv
module guard_cfg_lock
  import guard_timer_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [31:0]      wdata,
  output logic             load,
  output logic             locked,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] delta,
  output flags_t           flags
);
  assign load = cfg_wr && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      reload <= '1;
      delta  <= '1;
      flags  <= FLAGS_RESET;
    end else if (load) begin
      locked <= 1'b1;
      reload <= wdata[CNT_W-1:0];
      delta  <= wdata[CNT_W +: CNT_W];
      flags  <= flags_t'(wdata[FLAG_LSB +: $bits(flags_t)]);
    end
  end
endmodule

// File: rtl/guard_down_cnt.sv
module guard_down_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] delta,
  input  logic             kick,
  output logic [CNT_W-1:0] cnt,
  output logic             kick_ok,
  output logic             uf_ev,
  output logic             err_ev
);
  logic live_kick;
  logic live_step;

  assign live_kick = kick && run && !load;
  assign kick_ok   = live_kick && (cnt <= delta);
  assign err_ev    = live_kick && (cnt > delta);
  assign live_step = step && run && !load && !kick_ok;
  assign uf_ev     = live_step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '1;
    else if (load)      cnt <= load_val;
    else if (kick_ok)   cnt <= reload;
    else if (live_step) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int          PRESCALE = 128,
  parameter int          CNT_W    = 12,
  parameter logic [7:0]  KEY      = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        cpu_idle,
  input  logic        cpu_dbg_halt,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sys_rst_req,
  output logic        cpu_rst_req,
  output logic        fault_irq
);
  localparam int FW = $bits(flags_t);

  logic             tick;
  logic             mode_load;
  logic             locked;
  logic [CNT_W-1:0] reload_v;
  logic [CNT_W-1:0] delta_v;
  flags_t           fl;
  logic [CNT_W-1:0] cnt;
  logic             kick;
  logic             kick_ok;
  logic             uf_ev;
  logic             err_ev;
  logic             paused;
  logic             stat_rd;
  logic [1:0]       stat_q;
  logic [31:0]      mode_word;
  logic             fault;

  guard_tick_div #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .step(tick)
  );

  guard_cfg_lock #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(reg_wr && reg_addr == ADDR_CFG),
    .wdata(reg_wdata), .load(mode_load), .locked(locked),
    .reload(reload_v), .delta(delta_v), .flags(fl)
  );

  assign paused = (cpu_idle && fl.idle_hold) || (cpu_dbg_halt && fl.dbg_hold);
  assign kick   = reg_wr && reg_addr == ADDR_CMD && reg_wdata[31:24] == KEY && reg_wdata[0];

  guard_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .step(tick && !paused), .run(!fl.off),
    .load(mode_load), .load_val(reg_wdata[CNT_W-1:0]),
    .reload(reload_v), .delta(delta_v), .kick(kick),
    .cnt(cnt), .kick_ok(kick_ok), .uf_ev(uf_ev), .err_ev(err_ev)
  );

  assign fault   = uf_ev || err_ev;
  assign stat_rd = reg_rd && reg_addr == ADDR_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= '0;
      sys_rst_req <= 1'b0;
      cpu_rst_req <= 1'b0;
    end else begin
      stat_q      <= (stat_rd ? 2'b00 : stat_q) | {err_ev, uf_ev};
      sys_rst_req <= fault && fl.rst_en && !fl.proc_only;
      cpu_rst_req <= fault && fl.rst_en && fl.proc_only;
    end
  end

  assign fault_irq = fl.irq_en && (stat_q != 2'b00);

  always_comb begin
    mode_word = '0;
    mode_word[CNT_W-1:0]       = reload_v;
    mode_word[CNT_W +: CNT_W]  = delta_v;
    mode_word[FLAG_LSB +: FW]  = fl;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CFG:  reg_rdata = mode_word;
      ADDR_STAT: reg_rdata = {30'd0, stat_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             locked,
  input logic [31:0]      mode_word,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload_v,
  input logic             kick_ok,
  input logic             mode_load,
  input logic             off,
  input logic             sys_rst_req,
  input logic             cpu_rst_req,
  input logic             stat_rd,
  input logic             uf_ev,
  input logic             err_ev,
  input logic [1:0]       stat_q
);
  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(mode_word));

  a_r2_cnt_within_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload_v);

  a_r5_restart_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_ok && !mode_load) |=> (cnt == $past(reload_v)));

  a_r4_off_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(off) && off) |-> !(sys_rst_req || cpu_rst_req));

  a_r7_single_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && cpu_rst_req));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !uf_ev && !err_ev) |=> (stat_q == 2'b00));
endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .mode_word(mode_word),
  .cnt(cnt), .reload_v(reload_v), .kick_ok(kick_ok), .mode_load(mode_load),
  .off(fl.off), .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req),
  .stat_rd(stat_rd), .uf_ev(uf_ev), .err_ev(err_ev), .stat_q(stat_q)
);

// File: tb/guard_timer_test.sv
module guard_timer_test;
  localparam int P = 2;
  localparam logic [31:0] IRQ  = 32'h0100_0000;
  localparam logic [31:0] RST  = 32'h0200_0000;
  localparam logic [31:0] PROC = 32'h0400_0000;
  localparam logic [31:0] OFF  = 32'h0800_0000;
  localparam logic [31:0] IDLE = 32'h1000_0000;
  localparam logic [31:0] DBG  = 32'h2000_0000;
  localparam logic [31:0] GOOD = 32'hA500_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 0, cpu_idle = 0, cpu_dbg_halt = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sys_rst_req, cpu_rst_req, fault_irq;
  int tests = 0, fails = 0, sys_cnt = 0, cyc = 0;

  always #2.5 clk = ~clk;

  guard_timer #(.PRESCALE(P), .CNT_W(12), .KEY(8'hA5)) uut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cpu_idle(cpu_idle),
    .cpu_dbg_halt(cpu_dbg_halt), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sys_rst_req(sys_rst_req), .cpu_rst_req(cpu_rst_req), .fault_irq(fault_irq)
  );

  always @(posedge clk) begin
    if (sys_rst_req) sys_cnt++;
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cpu_idle = 0; cpu_dbg_halt = 0; slow_tick = 0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic steps(input int n);
    repeat (n * P) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(2'd2, v); chk("R1 status", v, 0);
    rd(2'd1, v); chk("R1 config", v, 32'h02FF_FFFF);
    chk("R1 outputs", {29'd0, sys_rst_req, cpu_rst_req, fault_irq}, 0);
    steps(4095);
    chk("R2 no reset before 4096 steps", sys_cnt, 0);
    steps(1);
    chk("R1 R7 sys reset at 4096th step", sys_rst_req, 1);
    rd(2'd2, v); chk("R8 underflow flag", v, 1);

    // R2 sweep of reload values, interrupt action
    for (int r = 0; r < 8; r++) begin
      do_reset();
      wr(2'd1, IRQ | (r << 12) | r);
      steps(r);
      chk("R2 no fault before reload+1", fault_irq, 0);
      steps(1);
      chk("R7 irq on underflow", fault_irq, 1);
      rd(2'd2, v); chk("R8 read returns underflow", v, 1);
      @(negedge clk); chk("R8 irq cleared by read", fault_irq, 0);
      rd(2'd2, v); chk("R8 status cleared", v, 0);
    end

    // R5 R6 window sweep: reload 6, limit 3
    for (int k = 0; k < 7; k++) begin
      do_reset();
      wr(2'd1, IRQ | (3 << 12) | 6);
      steps(k);
      wr(2'd0, GOOD);
      rd(2'd2, v);
      if (6 - k > 3) begin
        chk("R6 early restart error", v, 2);
        steps(6 - k); rd(2'd2, v); chk("R6 counter not reloaded", v, 0);
        steps(1);     rd(2'd2, v); chk("R6 underflow at old count", v, 1);
      end else begin
        chk("R5 restart in window", v, 0);
        steps(6); rd(2'd2, v); chk("R5 reloaded by restart", v, 0);
        steps(1); rd(2'd2, v); chk("R5 underflow after reload", v, 1);
      end
    end

    // R6 limit equal to reload: restart at any time
    do_reset();
    wr(2'd1, IRQ | (5 << 12) | 5);
    wr(2'd0, GOOD);
    rd(2'd2, v); chk("R6 limit==reload no error", v, 0);

    // R5 wrong key ignored
    do_reset();
    wr(2'd1, IRQ | (3 << 12) | 3);
    steps(2);
    wr(2'd0, 32'h5A00_0001);
    steps(1); rd(2'd2, v); chk("R5 bad key no reload", v, 0);
    steps(1); rd(2'd2, v); chk("R5 bad key underflow on time", v, 1);

    // R3 write-once
    do_reset();
    wr(2'd1, IRQ | (2 << 12) | 2);
    wr(2'd1, RST | (7 << 12) | 7);
    rd(2'd1, v); chk("R3 second write ignored", v, IRQ | (2 << 12) | 2);
    steps(2); chk("R3 first reload kept", fault_irq, 0);
    steps(1); chk("R3 fault at first reload", fault_irq, 1);

    // R4 off permanently
    do_reset();
    sys_cnt = 0;
    wr(2'd1, OFF | RST);
    steps(10);
    wr(2'd0, GOOD);
    wr(2'd1, IRQ);
    steps(3);
    rd(2'd2, v); chk("R4 off no status", v, 0);
    chk("R4 off no outputs", {30'd0, fault_irq, sys_cnt != 0}, 0);

    // R7 processor-only reset
    do_reset();
    wr(2'd1, RST | PROC | (1 << 12) | 1);
    steps(2);
    chk("R7 cpu reset pulse", {30'd0, cpu_rst_req, sys_rst_req}, 2);

    // R9 idle pause
    do_reset();
    wr(2'd1, IRQ | IDLE | (2 << 12) | 2);
    cpu_idle = 1; steps(5); cpu_idle = 0;
    rd(2'd2, v); chk("R9 idle holds counter", v, 0);
    steps(2); rd(2'd2, v); chk("R9 count resumes", v, 0);
    steps(1); rd(2'd2, v); chk("R9 underflow after resume", v, 1);

    // R9 debug pause, idle without its bit counts
    do_reset();
    wr(2'd1, IRQ | DBG | (2 << 12) | 2);
    cpu_dbg_halt = 1; steps(4); cpu_dbg_halt = 0;
    rd(2'd2, v); chk("R9 debug holds counter", v, 0);
    cpu_idle = 1; steps(3); cpu_idle = 0;
    rd(2'd2, v); chk("R9 idle ignored without bit", v, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule